// File: doc/BRIEF.md
# GCI Downstream Channel Extractor

This block sits on the receive side of a GCI line interface. The serial downstream line runs at 2.048 Mbit/s. Every 125 µs frame is 256 bits long and is split into eight GCI channels of four bytes each. Within a GCI channel the four bytes come in a fixed order: first B1, then B2, then the monitor byte, and last the signalling/control byte. A device on the bus owns two adjacent GCI channels, and a two-bit address picks which pair that is. The block follows the frame using the bit clock and the frame sync. It shifts in the serial data and hands each byte of the owned pair to the rest of the device as a one-cycle strobe. The strobe comes with the byte type, the slot within the pair, and the voice channel that the byte feeds.

Each B1 and B2 byte maps to one of four voice channels. The first GCI channel of the pair feeds voice channels 1 and 2. The second feeds voice channels 3 and 4. The monitor and signalling bytes are presented as they arrive, tagged only by slot. The block does not interpret them.

Top module: `gci_dn_extract`

## Requirements
- R1: During and right after reset, `byte_vld_o` is low and `byte_o`, `gci_slot_o`, `byte_kind_o` and `voice_o` are all zero.
- R2: No strobe is produced until the first frame sync has been seen after reset, whatever arrives on the data line.
- R3: Bits are sampled on rising clock edges, most significant bit first. `byte_o` carries the eight bits of the completed byte in that order.
- R4: When the address latched for a frame has value n, exactly the eight bytes of GCI channels 2n and 2n+1 are strobed in that frame. No other byte is strobed.
- R5: `byte_kind_o` gives the position of the byte within its GCI channel: 0 = B1, 1 = B2, 2 = monitor, 3 = signalling/control. Strobes leave in the order of arrival.
- R6: `gci_slot_o` is 0 for GCI channel 2n and 1 for GCI channel 2n+1. `voice_o` is 2·slot for B1 and 2·slot+1 for B2, which selects voice channels 1 to 4 as values 0 to 3. `voice_o` is 0 for monitor and signalling bytes.
- R7: Each strobe is high for exactly one clock. It is visible in the cycle right after the edge that samples the byte's eighth bit. A byte at frame bit offset k·8 therefore appears k·8+8 cycles after the edge that samples the frame sync.
- R8: A frame sync sampled high marks bit 0 of GCI channel 0 and restarts the bit count, even in the middle of a frame.
- R9: The address is latched on the frame sync. A change of `sel_i` in the middle of a frame takes effect only from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one data bit per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync_i | input | 1 | Frame sync, high during bit 0 of the frame |
| sdata_i | input | 1 | Downstream serial data |
| sel_i | input | SEL_W (2) | Address choosing the GCI channel pair |
| byte_vld_o | output | 1 | One-cycle strobe for an extracted byte |
| byte_o | output | BYTE_W (8) | Extracted byte |
| gci_slot_o | output | 1 | Which channel of the pair the byte came from |
| byte_kind_o | output | 2 | Byte type: B1, B2, monitor or signalling/control |
| voice_o | output | 2 | Voice channel index for B1/B2 bytes |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, four bytes per GCI channel and eight GCI channels, which gives a 256-bit frame and a two-bit address. With these values all four channel pairs can be reached within a few frames of random address and data, and so can the wrap of the bit counter at the frame end. Directed frames add the cases that depend on the exact bit count. These are a sync that arrives after a truncated frame, a mid-frame address change, and a long stretch of data with no sync at all.

// File: rtl/gci_dn_pkg.sv
package gci_dn_pkg;
   // position of a byte inside one GCI channel, in arrival order
   typedef enum logic [1:0] {
      KIND_B1  = 2'd0,
      KIND_B2  = 2'd1,
      KIND_MON = 2'd2,
      KIND_SC  = 2'd3
   } byte_kind_e;
endpackage

// File: rtl/gci_frame_counter.sv
module gci_frame_counter #(
   parameter int POS_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fsync_i,
   output logic [POS_W-1:0] pos_o,
   output logic             synced_o
);
   logic [POS_W-1:0] cnt_q;
   logic             synced_q;

   // bit position of the sample taken at this edge
   always_comb pos_o = fsync_i ? '0 : cnt_q + POS_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         synced_q <= 1'b0;
      end else begin
         cnt_q <= pos_o;
         if (fsync_i) synced_q <= 1'b1;
      end
   end

   assign synced_o = synced_q;
endmodule

// File: rtl/gci_byte_shifter.sv
module gci_byte_shifter #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdata_i,
   output logic [BYTE_W-1:0] byte_o
);
   logic [BYTE_W-2:0] sh_q;

   // earlier bits sit higher: first bit received ends up as MSB
   assign byte_o = {sh_q, sdata_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= byte_o[BYTE_W-2:0];
   end
endmodule

// File: rtl/gci_dn_extract.sv
module gci_dn_extract
   import gci_dn_pkg::*;
#(
   parameter int BYTE_W       = 8,
   parameter int BYTES_PER_CH = 4,
   parameter int NUM_GCI_CH   = 8,
   localparam int CH_W        = $clog2(NUM_GCI_CH),
   localparam int SEL_W       = CH_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fsync_i,
   input  logic              sdata_i,
   input  logic [SEL_W-1:0]  sel_i,
   output logic              byte_vld_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic              gci_slot_o,
   output logic [1:0]        byte_kind_o,
   output logic [1:0]        voice_o
);
   localparam int BIT_W  = $clog2(BYTE_W);
   localparam int BIDX_W = $clog2(BYTES_PER_CH);
   localparam int POS_W  = CH_W + BIDX_W + BIT_W;

   generate
      if (BYTES_PER_CH != 4) begin : g_bad_bytes
         $error("gci_dn_extract: BYTES_PER_CH must be 4");
      end
      if (NUM_GCI_CH < 4 || (NUM_GCI_CH & (NUM_GCI_CH - 1)) != 0) begin : g_bad_ch
         $error("gci_dn_extract: NUM_GCI_CH must be a power of two, at least 4");
      end
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_w
         $error("gci_dn_extract: BYTE_W must be a power of two, at least 2");
      end
   endgenerate

   logic [POS_W-1:0]  pos;
   logic              synced;
   logic [BYTE_W-1:0] cur_byte;
   logic [SEL_W-1:0]  sel_q;

   gci_frame_counter #(.POS_W(POS_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .fsync_i  (fsync_i),
      .pos_o    (pos),
      .synced_o (synced)
   );

   gci_byte_shifter #(.BYTE_W(BYTE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .sdata_i (sdata_i),
      .byte_o  (cur_byte)
   );

   // fields of the current bit position
   logic [BIT_W-1:0]  bit_idx;
   logic [BIDX_W-1:0] byte_idx;
   logic [CH_W-1:0]   gci_idx;
   logic              take;
   byte_kind_e        kind;

   always_comb begin
      bit_idx  = pos[BIT_W-1:0];
      byte_idx = pos[BIT_W +: BIDX_W];
      gci_idx  = pos[BIT_W+BIDX_W +: CH_W];
      kind     = byte_kind_e'(byte_idx[1:0]);
      take     = synced && (bit_idx == '1) && (gci_idx[CH_W-1:1] == sel_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else if (fsync_i) sel_q <= sel_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         byte_vld_o  <= 1'b0;
         byte_o      <= '0;
         gci_slot_o  <= 1'b0;
         byte_kind_o <= 2'd0;
         voice_o     <= 2'd0;
      end else begin
         byte_vld_o <= take;
         if (take) begin
            byte_o      <= cur_byte;
            gci_slot_o  <= gci_idx[0];
            byte_kind_o <= kind;
            voice_o     <= (kind == KIND_B1 || kind == KIND_B2) ?
                           {gci_idx[0], byte_idx[0]} : 2'd0;
         end
      end
   end

   // R7
   vld_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o);

   // R7
   vld_after_last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> ($past(pos[BIT_W-1:0]) == '1));

   // R2
   vld_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> synced);

   // R4
   vld_in_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |-> ($past(pos[POS_W-1 -: SEL_W]) == sel_q));

   // R6
   voice_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_o && byte_kind_o < 2'd2) |-> (voice_o[1] == gci_slot_o));
endmodule

// File: tb/gci_dn_extract_tb_top.sv
module gci_dn_extract_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       fsync = 1'b0;
   logic       sdata = 1'b0;
   logic [1:0] sel = 2'd0;
   logic       vld;
   logic [7:0] bo;
   logic       slot;
   logic [1:0] kind;
   logic [1:0] voice;

   gci_dn_extract dut_i (
      .clk (clk), .rst_n (rst_n), .fsync_i (fsync), .sdata_i (sdata),
      .sel_i (sel), .byte_vld_o (vld), .byte_o (bo), .gci_slot_o (slot),
      .byte_kind_o (kind), .voice_o (voice)
   );

   always #10 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic [7:0] cd [0:63];
   logic [1:0] ck [0:63];
   logic       cs [0:63];
   logic [1:0] cv [0:63];
   int         cc [0:63];
   int         cap_n = 0;

   always @(negedge clk) begin
      if (rst_n && vld) begin
         if (cap_n < 64) begin
            cd[cap_n] = bo; ck[cap_n] = kind; cs[cap_n] = slot;
            cv[cap_n] = voice; cc[cap_n] = cyc;
         end
         cap_n++;
      end
   end

   int errs = 0;
   int checks = 0;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_voice(input int sl, input int b);
      return (b < 2) ? sl * 2 + b : 0;
   endfunction

   function automatic int exp_cycle(input int s, input int idx);
      return s + idx * 8 + 8;
   endfunction

   // sa is used before bit sw, sb afterwards; frame of nbits bits
   task automatic run_frame(input logic [1:0] sa, input logic [1:0] sb,
                            input int sw, input int nbits, input bit check);
      logic [7:0] fr [0:31];
      int s = 0;
      for (int i = 0; i < 32; i++) fr[i] = 8'($urandom);
      @(posedge clk);
      cap_n = 0;
      for (int p = 0; p < nbits; p++) begin
         @(negedge clk);
         fsync = (p == 0);
         sdata = fr[p / 8][7 - (p % 8)];
         sel   = (p < sw) ? sa : sb;
         if (p == 0) s = cyc;
      end
      @(negedge clk);
      fsync = 1'b0;
      sdata = 1'b0;
      @(negedge clk);
      if (check) begin
         chk("R4", "strobes per frame", cap_n, 8);
         for (int j = 0; j < 8 && j < cap_n; j++) begin
            int sl  = j / 4;
            int b   = j % 4;
            int idx = (2 * int'(sa) + sl) * 4 + b;
            chk("R3", "byte value", int'(cd[j]), int'(fr[idx]));
            chk("R5", "byte kind", int'(ck[j]), b);
            chk("R6", "slot", int'(cs[j]), sl);
            chk("R6", "voice", int'(cv[j]), exp_voice(sl, b));
            chk("R7", "strobe cycle", cc[j], exp_cycle(s, idx));
         end
      end
   endtask

   initial begin
      #4000000;
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      // R1: outputs idle during reset
      chk("R1", "vld in reset", int'(vld), 0);
      chk("R1", "byte in reset", int'(bo), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "kind after reset", int'(kind), 0);
      chk("R1", "slot/voice after reset", int'({slot, voice}), 0);

      // R2: long stream with no frame sync
      for (int p = 0; p < 300; p++) begin
         @(negedge clk);
         sdata = 1'($urandom);
         sel   = 2'($urandom);
      end
      @(negedge clk);
      chk("R2", "strobes before sync", cap_n, 0);

      // directed: each pair in turn
      for (int n = 0; n < 4; n++) run_frame(2'(n), 2'(n), 256, 256, 1'b1);

      // R8: truncated frame then a fresh sync
      run_frame(2'd1, 2'd1, 256, 100, 1'b0);
      run_frame(2'd2, 2'd2, 256, 256, 1'b1);

      // R9: address change mid-frame ignored until next sync
      run_frame(2'd1, 2'd3, 100, 256, 1'b1);
      run_frame(2'd0, 2'd2, 37, 256, 1'b1);

      // random frames
      for (int f = 0; f < 16; f++) begin
         logic [1:0] a = 2'($urandom);
         logic [1:0] b = 2'($urandom);
         run_frame(a, b, int'($urandom % 256), 256, 1'b1);
      end

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule